// File: doc/BRIEF.md
# Password-Gated Sector Serial Memory

This block is a serial slave memory of 112 bytes, held as 14 sectors of 8 bytes. A host reaches it over a two-wire serial bus: a serial clock and an open-drain data line. The data line is seen here as a data input plus an output enable that pulls the line low. A chip-select input, active low, enables the block. Everything runs on one system clock, which oversamples the bus. Each session opens with a start condition and a command byte. Then come eight key bytes and one poll byte. The poll byte is acknowledged only when the key matched. Data moves after that. A read streams bytes from the first byte of the chosen sector for as long as the host acknowledges. A write takes exactly one sector of 8 bytes into a buffer. The buffer then goes through a timed nonvolatile write cycle before the array changes.

The controller is one state machine with these states:
- `ST_IDLE`: standby.
- `ST_CMD`: command byte.
- `ST_KEY`: key bytes.
- `ST_POLL`: acknowledge polling.
- `ST_WRITE`: write data.
- `ST_READ`: read stream.
- `ST_HOLD`: ignore bytes until the next start or stop.

The transitions are:
- A stop, or chip select going high, leads from any state to `ST_IDLE`.
- A start leads from any state to `ST_CMD`.
- An acknowledged command goes to `ST_KEY`. A refused command goes to `ST_HOLD`.
- The eighth key byte leads to `ST_POLL`.
- A poll that is acknowledged goes to `ST_READ` or `ST_WRITE`, according to the command. A poll that is refused stays in `ST_POLL`.
- The eighth write byte leads to `ST_HOLD` and starts the write cycle.
- A host not-acknowledge in `ST_READ` leads to `ST_HOLD`.

Top module: `keyed_sector_mem`

## Requirements
- R1: Command byte format:
  - Bit 7 set means read and bit 7 clear means write.
  - Bits 3:0 give the sector. Bits 6:4 are ignored.
  - A sector number above 13 is not acknowledged.
  - After a refused command, every further byte is left unacknowledged until the next start or stop.
- R2: Bus framing:
  - A start is the data line falling while the serial clock is high. A stop is the data line rising while the serial clock is high.
  - Bits are taken most significant first, on rising serial clock edges.
  - The block acknowledges a received byte by pulling the line low (sda_oe = 1) during the ninth clock.
- R3: Key bytes and key selection:
  - The eight key bytes are each acknowledged.
  - The first key byte is compared with the most significant byte of the key.
  - Reads are checked against READ_KEY and writes against WRITE_KEY. Both default to all zeros.
- R4: Acknowledge polling:
  - The byte after the key is a poll byte, and its value is ignored.
  - The poll is acknowledged only if all eight key bytes matched. On a mismatch, every poll is refused and no data moves.
- R5: Write length:
  - A write acknowledges exactly 8 data bytes, which are buffered for the first to last byte of the sector.
  - Any byte beyond the eighth is not acknowledged.
- R6: Write cycle:
  - The write cycle begins when the acknowledge clock of the eighth data byte ends, and lasts WR_CYCLES system clocks.
  - The buffer reaches the sector only when the count expires.
  - A command byte received while the cycle runs is not acknowledged.
- R7: Write cancel: a stop, or chip select going high, before the eighth data byte completes discards the write. No write cycle starts and the sector keeps its old contents.
- R8: Reads:
  - A read starts at the first byte of the sector and continues while the host acknowledges each byte.
  - The address crosses sector boundaries and wraps from byte 111 to byte 0.
  - A host not-acknowledge ends the stream, after which the line stays released.
- R9: Chip select:
  - With chip select high, the line is released (sda_oe = 0) within 4 system clocks and the block is in standby.
  - Bus activity while chip select is high gets no acknowledge.
- R10: After reset, every array byte is zero and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| scl | input | 1 | Serial clock from the host |
| sda_in | input | 1 | Level sensed on the serial data line |
| sda_oe | output | 1 | When 1, pull the serial data line low |

## Verification
The assertions check these properties on every cycle:
- The line is released in standby and in the hold state.
- A key mismatch never lets a poll be acknowledged.
- A command arriving during the write cycle gets no acknowledge.
- The write-cycle timer runs without a gap and is never restarted while busy.

Only the bench scenarios can show the following:
- Written data lands in the right sector, and only after the timer expires.
- A write cancelled by stop or by chip select leaves the old contents.
- A read stream crosses sectors and wraps at the end of the array.
- The right key is chosen for each direction.

// File: rtl/ksm_pkg.sv
package ksm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_KEY,
        ST_POLL,
        ST_WRITE,
        ST_READ,
        ST_HOLD
    } ksm_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/ksm_bus_sync.sv
module ksm_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic scl,
    input  logic sda_in,
    output logic sel,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_s
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_q;
    logic [DEPTH-1:0] sda_q;
    logic [STAGES-1:0] cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            cs_q  <= '1;
        end else begin
            scl_q <= {scl_q[DEPTH-2:0], scl};
            sda_q <= {sda_q[DEPTH-2:0], sda_in};
            cs_q  <= {cs_q[STAGES-2:0], cs_n};
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;

    always_comb begin
        scl_now  = scl_q[STAGES-1];
        scl_prev = scl_q[STAGES];
        sda_now  = sda_q[STAGES-1];
        sda_prev = sda_q[STAGES];
        sel      = !cs_q[STAGES-1];
        sda_s    = sda_now;
        scl_rise = sel && scl_now && !scl_prev;
        scl_fall = sel && !scl_now && scl_prev;
        start_ev = sel && scl_now && scl_prev && sda_prev && !sda_now;
        stop_ev  = sel && scl_now && scl_prev && !sda_prev && sda_now;
    end

endmodule

// File: rtl/ksm_nv_timer.sv
module ksm_nv_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start && cnt == '0) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // R6: the cycle runs without a gap until it expires
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6: a new cycle is never requested while one is running
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/ksm_sector_store.sv
module ksm_sector_store #(
    parameter int SECTORS      = 14,
    parameter int SECTOR_BYTES = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              buf_we,
    input  logic [$clog2(SECTOR_BYTES)-1:0]   buf_idx,
    input  logic [7:0]                        buf_data,
    input  logic                              commit,
    input  logic [$clog2(SECTORS)-1:0]        commit_sector,
    input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0] rd_addr,
    output logic [7:0]                        rd_data
);
    localparam int TOTAL = SECTORS * SECTOR_BYTES;
    localparam int AW    = $clog2(TOTAL);

    logic [7:0] mem  [TOTAL];
    logic [7:0] wbuf [SECTOR_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SECTOR_BYTES; i++) wbuf[i] <= '0;
        end else if (buf_we) begin
            wbuf[buf_idx] <= buf_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < SECTOR_BYTES; i++)
                mem[AW'(int'(commit_sector) * SECTOR_BYTES + i)] <= wbuf[i];
        end
    end

    assign rd_data = mem[rd_addr];

    // R1: only a sector inside the array can ever be committed
    p_commit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (int'(commit_sector) < SECTORS));

    // R5: the buffer is never loaded while a commit copies it
    p_buf_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !buf_we);

endmodule

// File: rtl/keyed_sector_mem.sv
module keyed_sector_mem
    import ksm_pkg::*;
#(
    parameter int SECTORS      = 14,
    parameter int SECTOR_BYTES = 8,
    parameter int KEY_BYTES    = 8,
    parameter int WR_CYCLES    = 1000,
    parameter logic [8*KEY_BYTES-1:0] READ_KEY  = '0,
    parameter logic [8*KEY_BYTES-1:0] WRITE_KEY = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic scl,
    input  logic sda_in,
    output logic sda_oe
);
    localparam int TOTAL = SECTORS * SECTOR_BYTES;
    localparam int AW    = $clog2(TOTAL);
    localparam int SW    = $clog2(SECTORS);
    localparam int DW    = $clog2(SECTOR_BYTES);
    localparam int IW    = (KEY_BYTES > SECTOR_BYTES) ? $clog2(KEY_BYTES) : DW;

    // bus events
    logic sel, rise, fall, start_ev, stop_ev, sda_s;

    ksm_bus_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .scl      (scl),
        .sda_in   (sda_in),
        .sel      (sel),
        .scl_rise (rise),
        .scl_fall (fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_s    (sda_s)
    );

    // controller state
    ksm_state_e state, state_d;
    logic [3:0]          bitcnt;
    logic                in_ack;
    logic                acked;
    logic                mack;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic [IW-1:0]       byte_idx;
    logic                key_bad;
    logic                is_read;
    logic [SW-1:0]       sector;
    logic [AW-1:0]       addr;
    logic                oe;

    // datapath helpers
    logic                nv_busy, nv_done, nv_start;
    logic                rx_state, byte_done, ack_end, abort;
    logic                ack_now, go_read, last_key, last_data, buf_we;
    logic [SW-1:0]       cmd_sector;
    logic [8*KEY_BYTES-1:0] key_vec;
    logic [BYTE_W-1:0]   key_byte;
    logic [AW-1:0]       base_addr, addr_nxt, rd_addr;
    logic [BYTE_W-1:0]   rd_data;
    logic [2:0]          bit_sel;

    ksm_nv_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (nv_busy),
        .done  (nv_done)
    );

    ksm_sector_store #(
        .SECTORS      (SECTORS),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .buf_we        (buf_we),
        .buf_idx       (byte_idx[DW-1:0]),
        .buf_data      (rx_sh),
        .commit        (nv_done),
        .commit_sector (sector),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data)
    );

    always_comb begin
        rx_state   = (state == ST_CMD) || (state == ST_KEY) ||
                     (state == ST_POLL) || (state == ST_WRITE);
        byte_done  = fall && !in_ack && (bitcnt == 4'd8);
        ack_end    = fall && in_ack;
        abort      = !sel || stop_ev;
        cmd_sector = rx_sh[SW-1:0];
        key_vec    = is_read ? READ_KEY : WRITE_KEY;
        key_byte   = key_vec[8*(KEY_BYTES-1-int'(byte_idx)) +: 8];
        last_key   = (byte_idx == IW'(KEY_BYTES-1));
        last_data  = (byte_idx == IW'(SECTOR_BYTES-1));
        base_addr  = AW'(int'(sector) * SECTOR_BYTES);
        addr_nxt   = (addr == AW'(TOTAL-1)) ? '0 : addr + 1'b1;
        rd_addr    = (state == ST_POLL) ? base_addr : addr_nxt;
        bit_sel    = 3'(4'd7 - bitcnt);
        go_read    = ack_end && (((state == ST_POLL) && acked && is_read) ||
                                 ((state == ST_READ) && mack));
        nv_start   = ack_end && (state == ST_WRITE) && last_data;
        buf_we     = byte_done && (state == ST_WRITE);
    end

    // acknowledge decision for a completed received byte
    always_comb begin
        unique case (state)
            ST_CMD:   ack_now = !nv_busy && (int'(cmd_sector) < SECTORS);
            ST_KEY:   ack_now = 1'b1;
            ST_POLL:  ack_now = !key_bad;
            ST_WRITE: ack_now = 1'b1;
            default:  ack_now = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state;
        if (abort) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_CMD;
        end else if (ack_end) begin
            unique case (state)
                ST_CMD:   state_d = acked ? ST_KEY : ST_HOLD;
                ST_KEY:   if (last_key) state_d = ST_POLL;
                ST_POLL:  if (acked) state_d = is_read ? ST_READ : ST_WRITE;
                ST_WRITE: if (last_data) state_d = ST_HOLD;
                ST_READ:  if (!mack) state_d = ST_HOLD;
                default:  state_d = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath: bit counting, shifting, key compare, addressing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            acked    <= 1'b0;
            mack     <= 1'b0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            byte_idx <= '0;
            key_bad  <= 1'b0;
            is_read  <= 1'b0;
            sector   <= '0;
            addr     <= '0;
        end else if (abort || start_ev) begin
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            byte_idx <= '0;
        end else begin
            if (rise && !in_ack && bitcnt < 4'd8 && rx_state) begin
                rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end
            if (rise && !in_ack && bitcnt < 4'd8 && state == ST_READ)
                bitcnt <= bitcnt + 1'b1;
            if (rise && in_ack && state == ST_READ)
                mack <= !sda_s;
            if (byte_done) begin
                in_ack <= 1'b1;
                acked  <= ack_now;
                if (state == ST_CMD && ack_now) begin
                    is_read <= rx_sh[BYTE_W-1];
                    sector  <= cmd_sector;
                    key_bad <= 1'b0;
                end
                if (state == ST_KEY)
                    key_bad <= key_bad || (rx_sh != key_byte);
            end
            if (ack_end) begin
                in_ack <= 1'b0;
                bitcnt <= '0;
                if (state == ST_KEY || state == ST_WRITE)
                    byte_idx <= ((state == ST_KEY) ? last_key : last_data) ?
                                '0 : byte_idx + 1'b1;
                if (go_read) begin
                    addr  <= (state == ST_POLL) ? base_addr : addr_nxt;
                    tx_sh <= rd_data;
                end
            end
        end
    end

    // output: open-drain pull-down enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe <= 1'b0;
        end else if (abort || start_ev) begin
            oe <= 1'b0;
        end else if (byte_done) begin
            oe <= ack_now;
        end else if (ack_end) begin
            oe <= go_read ? !rd_data[BYTE_W-1] : 1'b0;
        end else if (fall && state == ST_READ && !in_ack &&
                     bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
            oe <= !tx_sh[bit_sel];
        end
    end

    assign sda_oe = oe;

    // R9: deselect releases the line on the next clock
    p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !sda_oe);

    // R1: standby and hold never drive the line
    p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_HOLD) |-> !sda_oe);

    // R4: a failed key keeps every poll unacknowledged
    p_poll_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL && key_bad) |-> !sda_oe);

    // R6: a command during the write cycle is refused
    p_busy_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state == ST_CMD && nv_busy) |=> !sda_oe);

    // R6: the write cycle only starts from the write data state
    p_start_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nv_start |-> (state == ST_WRITE && !is_read));

endmodule

// File: tb/keyed_sector_mem_test.sv
module keyed_sector_mem_test;

    localparam int NSEC = 14;
    localparam int SB   = 8;
    localparam int TOT  = NSEC * SB;
    localparam int WRC  = 400;
    localparam int H    = 8;
    localparam logic [63:0] RK = 64'h1122_3344_5566_7788;
    localparam logic [63:0] WK = 64'hA1B2_C3D4_E5F6_0718;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic scl_r = 1'b1;
    logic msda = 1'b1;
    logic sda_oe;
    logic bus_sda;

    assign bus_sda = msda & ~sda_oe;

    always #2 clk = ~clk;

    keyed_sector_mem #(
        .SECTORS      (NSEC),
        .SECTOR_BYTES (SB),
        .KEY_BYTES    (8),
        .WR_CYCLES    (WRC),
        .READ_KEY     (RK),
        .WRITE_KEY    (WK)
    ) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .scl    (scl_r),
        .sda_in (bus_sda),
        .sda_oe (sda_oe)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] exp_mem [TOT];
    logic [7:0] rbuf [128];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 29 + i * 13 + 7) & 255);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; tick(H);
        scl_r = 1'b1; tick(H);
        msda = 1'b0; tick(H);
        scl_r = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        msda = 1'b0; tick(H);
        scl_r = 1'b1; tick(H);
        msda = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; tick(H);
            scl_r = 1'b1; tick(H);
            scl_r = 1'b0;
        end
        msda = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b);
        scl_r = 1'b1; tick(H);
        ack = !bus_sda;
        scl_r = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        msda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl_r = 1'b1; tick(H);
            b[i] = bus_sda;
            scl_r = 1'b0;
        end
        msda = give_ack ? 1'b0 : 1'b1; tick(H);
        scl_r = 1'b1; tick(H);
        scl_r = 1'b0; tick(2);
        msda = 1'b1;
    endtask

    task automatic send_key(input logic [63:0] key);
        logic a;
        for (int k = 0; k < 8; k++) send_byte(key[63-8*k -: 8], a);
    endtask

    task automatic rd_txn(input int sec, input logic [63:0] key, input int n,
                          output logic ca, output logic pa);
        bus_start();
        send_byte(8'h80 | 8'(sec), ca);
        pa = 1'b0;
        if (ca) begin
            send_key(key);
            send_byte(8'hFF, pa);
            if (pa) for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        end
        bus_stop();
    endtask

    task automatic wr_txn(input int sec, input logic [63:0] key, input int n,
                          input int seed, input bit do_stop,
                          output logic ca, output logic pa, output int dack);
        logic a;
        dack = 0;
        pa = 1'b0;
        bus_start();
        send_byte(8'(sec), ca);
        if (ca) begin
            send_key(key);
            send_byte(8'h3C, pa);
            if (pa) for (int i = 0; i < n; i++) begin
                send_byte(pat(seed, i), a);
                if (a) dack++;
            end
        end
        if (do_stop) bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ca, pa, a;
        logic [7:0] b;
        int dack;
        for (int i = 0; i < TOT; i++) exp_mem[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk(sda_oe == 1'b0, "R10 line released after reset", 32'(sda_oe), 0);
        cs_n = 1'b0;
        tick(H);

        // R10: reset contents, R3 read key accepted, R2 acks
        rd_txn(0, RK, 8, ca, pa);
        chk(ca == 1'b1, "R2 command ack", 32'(ca), 1);
        chk(pa == 1'b1, "R3 read key poll", 32'(pa), 1);
        for (int i = 0; i < 8; i++)
            chk(rbuf[i] == 8'h00, "R10 reset byte", 32'(rbuf[i]), 0);

        // R1: sectors 14 and 15 refused, then bytes ignored in hold
        bus_start();
        send_byte(8'h0E, a);
        chk(a == 1'b0, "R1 sector 14 refused", 32'(a), 0);
        send_byte(8'h00, a);
        chk(a == 1'b0, "R1 byte after refusal ignored", 32'(a), 0);
        bus_stop();
        bus_start();
        send_byte(8'h8F, a);
        chk(a == 1'b0, "R1 sector 15 refused", 32'(a), 0);
        bus_stop();

        // R4: wrong key for a read, repeated polls refused
        bus_start();
        send_byte(8'h82, a);
        send_key(WK);
        send_byte(8'hFF, a);
        chk(a == 1'b0, "R4 first poll with wrong key", 32'(a), 0);
        send_byte(8'hFF, a);
        chk(a == 1'b0, "R4 second poll with wrong key", 32'(a), 0);
        bus_stop();

        // R3: the read key does not open a write
        wr_txn(3, RK, 8, 77, 1'b1, ca, pa, dack);
        chk(pa == 1'b0, "R3 read key refused for write", 32'(pa), 0);
        tick(WRC + 50);
        rd_txn(3, RK, 8, ca, pa);
        for (int i = 0; i < 8; i++)
            chk(rbuf[i] == 8'h00, "R4 sector unchanged after refused write",
                32'(rbuf[i]), 0);

        // sweep: write every sector with its own pattern
        for (int s = 0; s < NSEC; s++) begin
            wr_txn(s, WK, (s == 0) ? 9 : 8, s, 1'b1, ca, pa, dack);
            chk(ca == 1'b1, "R1 write command ack", 32'(ca), 1);
            chk(pa == 1'b1, "R3 write key poll", 32'(pa), 1);
            chk(dack == 8, "R5 eight data bytes acknowledged", 32'(dack), 8);
            for (int i = 0; i < SB; i++) exp_mem[s*SB + i] = pat(s, i);
            if (s == 1) begin
                bus_start();
                send_byte(8'h80, a);
                chk(a == 1'b0, "R6 command refused during write cycle", 32'(a), 0);
                bus_stop();
            end
            tick(WRC + 50);
            if (s == 1) begin
                rd_txn(1, RK, 8, ca, pa);
                chk(ca == 1'b1, "R6 command accepted after cycle", 32'(ca), 1);
                for (int i = 0; i < 8; i++)
                    chk(rbuf[i] == exp_mem[8 + i], "R6 committed byte",
                        32'(rbuf[i]), 32'(exp_mem[8 + i]));
            end
        end

        // R8: one stream across all sectors and past the end
        rd_txn(0, RK, TOT + 2, ca, pa);
        for (int i = 0; i < TOT + 2; i++)
            chk(rbuf[i] == exp_mem[i % TOT], "R8 stream byte",
                32'(rbuf[i]), 32'(exp_mem[i % TOT]));

        // R8: start at the last sector and wrap
        rd_txn(13, RK, 10, ca, pa);
        for (int i = 0; i < 10; i++)
            chk(rbuf[i] == exp_mem[(104 + i) % TOT], "R8 wrap byte",
                32'(rbuf[i]), 32'(exp_mem[(104 + i) % TOT]));

        // R8: host not-acknowledge ends the stream
        bus_start();
        send_byte(8'h82, a);
        send_key(RK);
        send_byte(8'hFF, a);
        recv_byte(1'b0, b);
        chk(b == exp_mem[16], "R8 first byte before host nack", 32'(b),
            32'(exp_mem[16]));
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R8 line released after host nack", 32'(b), 32'hFF);
        bus_stop();

        // R7: stop before the eighth byte cancels
        wr_txn(5, WK, 5, 99, 1'b1, ca, pa, dack);
        rd_txn(5, RK, 8, ca, pa);
        chk(ca == 1'b1, "R7 no write cycle after cancel", 32'(ca), 1);
        for (int i = 0; i < 8; i++)
            chk(rbuf[i] == exp_mem[40 + i], "R7 sector kept after stop cancel",
                32'(rbuf[i]), 32'(exp_mem[40 + i]));

        // R7: chip select high before the eighth byte cancels
        wr_txn(6, WK, 7, 98, 1'b0, ca, pa, dack);
        cs_n = 1'b1; tick(H);
        cs_n = 1'b0; tick(H);
        rd_txn(6, RK, 8, ca, pa);
        chk(ca == 1'b1, "R7 no write cycle after deselect", 32'(ca), 1);
        for (int i = 0; i < 8; i++)
            chk(rbuf[i] == exp_mem[48 + i], "R7 sector kept after deselect",
                32'(rbuf[i]), 32'(exp_mem[48 + i]));

        // R9: deselect during an acknowledge releases the line
        bus_start();
        send_bits(8'h84);
        chk(sda_oe == 1'b1, "R2 acknowledge driven", 32'(sda_oe), 1);
        cs_n = 1'b1; tick(4);
        chk(sda_oe == 1'b0, "R9 released after deselect", 32'(sda_oe), 0);
        scl_r = 1'b0; tick(H);

        // R9: activity while deselected gets no acknowledge
        bus_start();
        send_byte(8'h80, a);
        chk(a == 1'b0, "R9 no ack while deselected", 32'(a), 0);
        bus_stop();
        cs_n = 1'b0; tick(H);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule